// File: doc/BRIEF.md
# Pipeline Stall and Flush Controller

This block is the hazard controller of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It collects the separate stall requests raised around the core: a cache writeback for an instruction-cache resync, an instruction-cache miss, a data-cache miss, a load-use hazard and a busy multiply/divide unit. It reduces them to one encoded stall cause under a fixed priority. From that cause it drives the load enable of every stage register and tells the execute register when to take a bubble.

The controller finds load-use hazards on its own by comparing the destination of a load in the execute slot against both source registers of the decode slot. It also accepts an external load-use request. Raw flush requests for the decode and execute registers are gated. While a memory or ALU stall holds the pipeline, a flush is remembered rather than applied, and it is released in the first cycle that the stall no longer blocks it.

When the execute slot holds an instruction-cache resync instruction, or a CSR write to address 0x301, the controller requests a front-end resync. Fetch restarts at that instruction's next PC. The controller also produces the operand-forwarding selects for the execute and decode stages. All outputs are combinational in the current inputs, except the deferred flushes, which come from two pending registers.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: `stall_cause_o` encodes the active stall as 0 = none, 1 = instruction miss, 2 = data miss, 3 = load-use, 4 = ALU busy, 5 = cache-resync writeback. With no request active it reads 0.
- R2: When several stall requests are active together, the cause follows a fixed order from highest to lowest: resync writeback, instruction miss, data miss, load-use, ALU busy.
- R3: Causes 5, 2 and 4 drive all five stage enables (`fetch_en_o`, `dec_en_o`, `exe_en_o`, `mem_en_o`, `wb_en_o`) low.
- R4: Causes 1 and 3 drive only `fetch_en_o` and `dec_en_o` low and raise `exe_bubble_o`, so that the execute register loads a bubble. For every other cause `exe_bubble_o` is low.
- R5: A load-use hazard (cause 3) is detected when `exe_is_load_i` is high, `exe_rd_i` is nonzero, and `exe_rd_i` equals `dec_rs1_i` or `dec_rs2_i`. A zero destination never raises it. Detection lasts only as long as the condition holds, so a load that advances yields exactly one bubble.
- R6: While the cause is 1, 2, 4 or 5, `dec_flush_o` and `exe_flush_o` are low, whatever the raw flush requests are.
- R7: A raw flush request seen while it is blocked is kept. It appears on its flush output for one cycle, in the first cycle the cause is 0 or 3. An unblocked raw request appears on its output in the same cycle.
- R8: `resync_o` is high, and `resync_pc_o` equals `exe_pc_next_i`, when `exe_is_fencei_i` is high or when `exe_csr_we_i` is high with `exe_csr_addr_i` = 0x301. No other CSR address raises it, and no stall masks it.
- R9: `exe_fwd_a_o` and `exe_fwd_b_o` select 0 = register file, 1 = memory-stage result, 2 = writeback result. They pick the memory stage first when both stages write the execute source, and never forward register 0.
- R10: `dec_byp_a_o` and `dec_byp_b_o` are high when writeback is writing a nonzero register equal to the respective decode source.
- R11: With cause 0 all five stage enables are high and `exe_bubble_o` is low.
- R12: Reset clears any pending flush, so that after reset, with all inputs low, both flush outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| resync_wb_req_i | input | 1 | Cache writeback pending for a resync |
| imiss_req_i | input | 1 | Instruction cache miss |
| dmiss_req_i | input | 1 | Data cache miss |
| lduse_ext_req_i | input | 1 | Externally raised load-use hold |
| alu_busy_req_i | input | 1 | Multiply/divide still busy |
| dec_flush_req_i | input | 1 | Raw flush request for the decode register |
| exe_flush_req_i | input | 1 | Raw flush request for the execute register |
| dec_rs1_i | input | REG_AW | Decode slot source 1 |
| dec_rs2_i | input | REG_AW | Decode slot source 2 |
| exe_rs1_i | input | REG_AW | Execute slot source 1 |
| exe_rs2_i | input | REG_AW | Execute slot source 2 |
| exe_rd_i | input | REG_AW | Execute slot destination |
| exe_is_load_i | input | 1 | Execute slot holds a load |
| exe_is_fencei_i | input | 1 | Execute slot holds a cache-resync instruction |
| exe_csr_we_i | input | 1 | Execute slot writes a CSR |
| exe_csr_addr_i | input | 12 | CSR address of that write |
| exe_pc_next_i | input | XLEN | Next PC of the execute slot instruction |
| mem_rd_i | input | REG_AW | Memory stage destination |
| mem_rf_we_i | input | 1 | Memory stage writes the register file |
| wb_rd_i | input | REG_AW | Writeback destination |
| wb_rf_we_i | input | 1 | Writeback writes the register file |
| stall_cause_o | output | 3 | Encoded stall cause |
| fetch_en_o | output | 1 | Fetch PC advance enable |
| dec_en_o | output | 1 | Fetch/decode register load enable |
| exe_en_o | output | 1 | Decode/execute register load enable |
| mem_en_o | output | 1 | Execute/memory register load enable |
| wb_en_o | output | 1 | Memory/writeback register load enable |
| exe_bubble_o | output | 1 | Execute register loads a bubble |
| dec_flush_o | output | 1 | Gated flush of the decode register |
| exe_flush_o | output | 1 | Gated flush of the execute register |
| resync_o | output | 1 | Front-end resync request |
| resync_pc_o | output | XLEN | PC at which fetch resumes |
| exe_fwd_a_o | output | 2 | Execute operand A forwarding select |
| exe_fwd_b_o | output | 2 | Execute operand B forwarding select |
| dec_byp_a_o | output | 1 | Decode source 1 writeback bypass |
| dec_byp_b_o | output | 1 | Decode source 2 writeback bypass |

## Verification
Every output except the two flush outputs is due in the same cycle as its inputs. The bench therefore drives each pattern just after a falling edge and samples about a nanosecond later, before the next rising edge can change anything. A flush that was held back is due in the first cycle whose cause no longer blocks it, one or more rising edges after the request. The deferral tests step one cycle at a time and check that the output is low on every blocked cycle, high on the release cycle and low again on the cycle after. The single-bubble property of a load-use hazard is checked the same way: across the cycle with the hazard and the cycle after the load has moved on.

// File: rtl/hzc_pkg.sv
`timescale 1ns/1ps
package hzc_pkg;

    typedef enum logic [2:0] {
        STALL_NONE   = 3'd0,
        STALL_IMISS  = 3'd1,
        STALL_DMISS  = 3'd2,
        STALL_LDUSE  = 3'd3,
        STALL_ALU    = 3'd4,
        STALL_RESYNC = 3'd5
    } stall_cause_e;

    typedef enum logic [1:0] {
        FWD_RF  = 2'd0,
        FWD_MEM = 2'd1,
        FWD_WB  = 2'd2
    } fwd_sel_e;

    typedef struct packed {
        logic fetch;
        logic dec;
        logic exe;
        logic mem;
        logic wb;
    } stage_en_t;

    // Causes during which a flush must wait (memory or ALU holds)
    function automatic logic cause_blocks_flush(stall_cause_e c);
        return (c == STALL_IMISS) || (c == STALL_DMISS) ||
               (c == STALL_ALU)   || (c == STALL_RESYNC);
    endfunction

endpackage

// File: rtl/hzc_stall_arbiter.sv
`timescale 1ns/1ps
module hzc_stall_arbiter
    import hzc_pkg::*;
(
    input  logic         resync_req_i,
    input  logic         imiss_req_i,
    input  logic         dmiss_req_i,
    input  logic         lduse_req_i,
    input  logic         alu_req_i,
    output stall_cause_e cause_o,
    output stage_en_t    en_o,
    output logic         bubble_o
);

    // Fixed priority: resync writeback above all, ALU busy lowest
    always_comb begin
        cause_o = STALL_NONE;
        if (resync_req_i)      cause_o = STALL_RESYNC;
        else if (imiss_req_i)  cause_o = STALL_IMISS;
        else if (dmiss_req_i)  cause_o = STALL_DMISS;
        else if (lduse_req_i)  cause_o = STALL_LDUSE;
        else if (alu_req_i)    cause_o = STALL_ALU;
    end

    // Stage freeze pattern per cause
    always_comb begin
        en_o     = '{fetch: 1'b1, dec: 1'b1, exe: 1'b1, mem: 1'b1, wb: 1'b1};
        bubble_o = 1'b0;
        unique case (cause_o)
            STALL_RESYNC, STALL_DMISS, STALL_ALU: begin
                en_o = '0;
            end
            STALL_IMISS, STALL_LDUSE: begin
                en_o.fetch = 1'b0;
                en_o.dec   = 1'b0;
                bubble_o   = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/hzc_ldu_detect.sv
`timescale 1ns/1ps
module hzc_ldu_detect #(
    parameter int REG_AW  = 5,
    parameter int NUM_SRC = 2
) (
    input  logic                           exe_is_load_i,
    input  logic [REG_AW-1:0]              exe_rd_i,
    input  logic [NUM_SRC-1:0][REG_AW-1:0] dec_rs_i,
    output logic                           hit_o
);

    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic [NUM_SRC-1:0] src_match;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign src_match[g] = (dec_rs_i[g] == exe_rd_i);
    end

    assign hit_o = exe_is_load_i && (exe_rd_i != ZERO_REG) && (|src_match);

endmodule

// File: rtl/hzc_fwd_unit.sv
`timescale 1ns/1ps
module hzc_fwd_unit
    import hzc_pkg::*;
#(
    parameter int REG_AW  = 5,
    parameter int NUM_SRC = 2
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic [NUM_SRC-1:0][REG_AW-1:0] exe_rs_i,
    input  logic [NUM_SRC-1:0][REG_AW-1:0] dec_rs_i,
    input  logic [REG_AW-1:0]              mem_rd_i,
    input  logic                           mem_we_i,
    input  logic [REG_AW-1:0]              wb_rd_i,
    input  logic                           wb_we_i,
    output logic [NUM_SRC-1:0][1:0]        exe_sel_o,
    output logic [NUM_SRC-1:0]             dec_byp_o
);

    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic mem_live;
    logic wb_live;

    assign mem_live = mem_we_i && (mem_rd_i != ZERO_REG);
    assign wb_live  = wb_we_i  && (wb_rd_i  != ZERO_REG);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        // Youngest producer (memory stage) wins
        always_comb begin
            if (mem_live && (exe_rs_i[g] == mem_rd_i))     exe_sel_o[g] = FWD_MEM;
            else if (wb_live && (exe_rs_i[g] == wb_rd_i))  exe_sel_o[g] = FWD_WB;
            else                                           exe_sel_o[g] = FWD_RF;
        end

        assign dec_byp_o[g] = wb_live && (dec_rs_i[g] == wb_rd_i);

        // R9
        x0_not_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (exe_rs_i[g] == ZERO_REG) |-> (exe_sel_o[g] == 2'(FWD_RF)));

        // R9
        mem_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (exe_sel_o[g] == 2'(FWD_WB)) |-> !(mem_live && (exe_rs_i[g] == mem_rd_i)));
    end

endmodule

// File: rtl/hzc_flush_gate.sv
`timescale 1ns/1ps
module hzc_flush_gate
    import hzc_pkg::*;
#(
    parameter int NUM_TGT = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  stall_cause_e       cause_i,
    input  logic [NUM_TGT-1:0] req_i,
    output logic [NUM_TGT-1:0] flush_o
);

    typedef struct packed {
        logic [NUM_TGT-1:0] pend;
        logic               up;
    } gate_st_t;

    gate_st_t st_d;
    gate_st_t st_q;
    logic     blocked;

    assign blocked = cause_blocks_flush(cause_i);

    always_comb begin
        st_d    = st_q;
        st_d.up = 1'b1;
        flush_o = '0;
        for (int i = 0; i < NUM_TGT; i++) begin
            if (blocked) begin
                st_d.pend[i] = st_q.pend[i] | req_i[i];
            end else begin
                flush_o[i]   = st_q.pend[i] | req_i[i];
                st_d.pend[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    for (genvar g = 0; g < NUM_TGT; g++) begin : g_chk
        // R7
        deferred_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (st_q.up && $past(blocked) && $past(req_i[g]) && !blocked) |-> flush_o[g]);

        // R7
        flush_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (st_q.up && $past(flush_o[g]) && !req_i[g]) |-> !flush_o[g]);
    end

endmodule

// File: rtl/pipe_hazard_ctrl.sv
`timescale 1ns/1ps
module pipe_hazard_ctrl
    import hzc_pkg::*;
#(
    parameter int          XLEN         = 32,
    parameter int          REG_AW       = 5,
    parameter logic [11:0] CSR_ISA_ADDR = 12'h301
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              resync_wb_req_i,
    input  logic              imiss_req_i,
    input  logic              dmiss_req_i,
    input  logic              lduse_ext_req_i,
    input  logic              alu_busy_req_i,
    input  logic              dec_flush_req_i,
    input  logic              exe_flush_req_i,
    input  logic [REG_AW-1:0] dec_rs1_i,
    input  logic [REG_AW-1:0] dec_rs2_i,
    input  logic [REG_AW-1:0] exe_rs1_i,
    input  logic [REG_AW-1:0] exe_rs2_i,
    input  logic [REG_AW-1:0] exe_rd_i,
    input  logic              exe_is_load_i,
    input  logic              exe_is_fencei_i,
    input  logic              exe_csr_we_i,
    input  logic [11:0]       exe_csr_addr_i,
    input  logic [XLEN-1:0]   exe_pc_next_i,
    input  logic [REG_AW-1:0] mem_rd_i,
    input  logic              mem_rf_we_i,
    input  logic [REG_AW-1:0] wb_rd_i,
    input  logic              wb_rf_we_i,
    output logic [2:0]        stall_cause_o,
    output logic              fetch_en_o,
    output logic              dec_en_o,
    output logic              exe_en_o,
    output logic              mem_en_o,
    output logic              wb_en_o,
    output logic              exe_bubble_o,
    output logic              dec_flush_o,
    output logic              exe_flush_o,
    output logic              resync_o,
    output logic [XLEN-1:0]   resync_pc_o,
    output logic [1:0]        exe_fwd_a_o,
    output logic [1:0]        exe_fwd_b_o,
    output logic              dec_byp_a_o,
    output logic              dec_byp_b_o
);

    localparam int NUM_SRC = 2;
    localparam int NUM_TGT = 2;

    logic                           ldu_hit;
    stall_cause_e                   cause;
    stage_en_t                      stage_en;
    logic [NUM_TGT-1:0]             flush_vec;
    logic [NUM_SRC-1:0][1:0]        exe_sel;
    logic [NUM_SRC-1:0]             dec_byp;

    hzc_ldu_detect #(
        .REG_AW  (REG_AW),
        .NUM_SRC (NUM_SRC)
    ) u_ldu (
        .exe_is_load_i (exe_is_load_i),
        .exe_rd_i      (exe_rd_i),
        .dec_rs_i      ({dec_rs2_i, dec_rs1_i}),
        .hit_o         (ldu_hit)
    );

    hzc_stall_arbiter u_arb (
        .resync_req_i (resync_wb_req_i),
        .imiss_req_i  (imiss_req_i),
        .dmiss_req_i  (dmiss_req_i),
        .lduse_req_i  (ldu_hit | lduse_ext_req_i),
        .alu_req_i    (alu_busy_req_i),
        .cause_o      (cause),
        .en_o         (stage_en),
        .bubble_o     (exe_bubble_o)
    );

    hzc_flush_gate #(
        .NUM_TGT (NUM_TGT)
    ) u_gate (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .cause_i (cause),
        .req_i   ({exe_flush_req_i, dec_flush_req_i}),
        .flush_o (flush_vec)
    );

    hzc_fwd_unit #(
        .REG_AW  (REG_AW),
        .NUM_SRC (NUM_SRC)
    ) u_fwd (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .exe_rs_i  ({exe_rs2_i, exe_rs1_i}),
        .dec_rs_i  ({dec_rs2_i, dec_rs1_i}),
        .mem_rd_i  (mem_rd_i),
        .mem_we_i  (mem_rf_we_i),
        .wb_rd_i   (wb_rd_i),
        .wb_we_i   (wb_rf_we_i),
        .exe_sel_o (exe_sel),
        .dec_byp_o (dec_byp)
    );

    assign stall_cause_o = cause;
    assign fetch_en_o    = stage_en.fetch;
    assign dec_en_o      = stage_en.dec;
    assign exe_en_o      = stage_en.exe;
    assign mem_en_o      = stage_en.mem;
    assign wb_en_o       = stage_en.wb;
    assign dec_flush_o   = flush_vec[0];
    assign exe_flush_o   = flush_vec[1];
    assign exe_fwd_a_o   = exe_sel[0];
    assign exe_fwd_b_o   = exe_sel[1];
    assign dec_byp_a_o   = dec_byp[0];
    assign dec_byp_b_o   = dec_byp[1];

    // Front-end resync: cache-resync instruction or ISA-register write
    assign resync_o    = exe_is_fencei_i || (exe_csr_we_i && (exe_csr_addr_i == CSR_ISA_ADDR));
    assign resync_pc_o = exe_pc_next_i;

    // R2
    resync_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        resync_wb_req_i |-> (stall_cause_o == 3'(STALL_RESYNC)));

    // R3
    freeze_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stall_cause_o inside {3'(STALL_RESYNC), 3'(STALL_DMISS), 3'(STALL_ALU)})
        |-> !(exe_en_o || mem_en_o || wb_en_o));

    // R4
    bubble_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exe_bubble_o |-> (!dec_en_o && exe_en_o));

    // R5
    lduse_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ldu_hit && !resync_wb_req_i && !imiss_req_i && !dmiss_req_i)
        |-> (stall_cause_o == 3'(STALL_LDUSE)));

    // R6
    flush_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stall_cause_o inside {3'(STALL_IMISS), 3'(STALL_DMISS), 3'(STALL_ALU), 3'(STALL_RESYNC)})
        |-> !(dec_flush_o || exe_flush_o));

endmodule

// File: tb/pipe_hazard_ctrl_test.sv
`timescale 1ns/1ps
module pipe_hazard_ctrl_test;

    localparam int XLEN   = 32;
    localparam int REG_AW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic              resync_wb_req, imiss_req, dmiss_req, lduse_ext_req, alu_busy_req;
    logic              dec_flush_req, exe_flush_req;
    logic [REG_AW-1:0] dec_rs1, dec_rs2, exe_rs1, exe_rs2, exe_rd, mem_rd, wb_rd;
    logic              exe_is_load, exe_is_fencei, exe_csr_we, mem_rf_we, wb_rf_we;
    logic [11:0]       exe_csr_addr;
    logic [XLEN-1:0]   exe_pc_next;

    logic [2:0]        stall_cause;
    logic              fetch_en, dec_en, exe_en, mem_en, wb_en, exe_bubble;
    logic              dec_flush, exe_flush, resync;
    logic [XLEN-1:0]   resync_pc;
    logic [1:0]        fwd_a, fwd_b;
    logic              byp_a, byp_b;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    pipe_hazard_ctrl #(.XLEN(XLEN), .REG_AW(REG_AW)) uut (
        .clk_i(clk), .rst_ni(rst_n),
        .resync_wb_req_i(resync_wb_req), .imiss_req_i(imiss_req), .dmiss_req_i(dmiss_req),
        .lduse_ext_req_i(lduse_ext_req), .alu_busy_req_i(alu_busy_req),
        .dec_flush_req_i(dec_flush_req), .exe_flush_req_i(exe_flush_req),
        .dec_rs1_i(dec_rs1), .dec_rs2_i(dec_rs2), .exe_rs1_i(exe_rs1), .exe_rs2_i(exe_rs2),
        .exe_rd_i(exe_rd), .exe_is_load_i(exe_is_load), .exe_is_fencei_i(exe_is_fencei),
        .exe_csr_we_i(exe_csr_we), .exe_csr_addr_i(exe_csr_addr), .exe_pc_next_i(exe_pc_next),
        .mem_rd_i(mem_rd), .mem_rf_we_i(mem_rf_we), .wb_rd_i(wb_rd), .wb_rf_we_i(wb_rf_we),
        .stall_cause_o(stall_cause), .fetch_en_o(fetch_en), .dec_en_o(dec_en),
        .exe_en_o(exe_en), .mem_en_o(mem_en), .wb_en_o(wb_en), .exe_bubble_o(exe_bubble),
        .dec_flush_o(dec_flush), .exe_flush_o(exe_flush), .resync_o(resync),
        .resync_pc_o(resync_pc), .exe_fwd_a_o(fwd_a), .exe_fwd_b_o(fwd_b),
        .dec_byp_a_o(byp_a), .dec_byp_b_o(byp_b)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        resync_wb_req = 0; imiss_req = 0; dmiss_req = 0; lduse_ext_req = 0; alu_busy_req = 0;
        dec_flush_req = 0; exe_flush_req = 0;
        dec_rs1 = 0; dec_rs2 = 0; exe_rs1 = 0; exe_rs2 = 0; exe_rd = 0; mem_rd = 0; wb_rd = 0;
        exe_is_load = 0; exe_is_fencei = 0; exe_csr_we = 0; mem_rf_we = 0; wb_rf_we = 0;
        exe_csr_addr = 0; exe_pc_next = 0;
    endtask

    // Drive point: just after a falling edge; outputs sampled 1 ns later
    task automatic next_slot();
        @(negedge clk);
    endtask

    function automatic logic [4:0] ens();
        return {fetch_en, dec_en, exe_en, mem_en, wb_en};
    endfunction

    task automatic test_reset();
        next_slot(); idle_inputs(); #1;
        chk("R12", "cause after reset", 32'(stall_cause), 0);
        chk("R12", "flushes after reset", {30'd0, exe_flush, dec_flush}, 0);
        chk("R11", "enables idle", 32'(ens()), 5'b11111);
        chk("R11", "bubble idle", 32'(exe_bubble), 0);
        chk("R8", "no resync idle", 32'(resync), 0);
    endtask

    task automatic test_encoding();
        next_slot(); idle_inputs(); imiss_req = 1; #1;
        chk("R1", "imiss code", 32'(stall_cause), 1);
        next_slot(); idle_inputs(); dmiss_req = 1; #1;
        chk("R1", "dmiss code", 32'(stall_cause), 2);
        next_slot(); idle_inputs(); lduse_ext_req = 1; #1;
        chk("R1", "lduse code", 32'(stall_cause), 3);
        next_slot(); idle_inputs(); alu_busy_req = 1; #1;
        chk("R1", "alu code", 32'(stall_cause), 4);
        next_slot(); idle_inputs(); resync_wb_req = 1; #1;
        chk("R1", "resync code", 32'(stall_cause), 5);
        next_slot(); idle_inputs(); #1;
    endtask

    task automatic test_priority();
        next_slot(); idle_inputs();
        resync_wb_req = 1; imiss_req = 1; dmiss_req = 1; lduse_ext_req = 1; alu_busy_req = 1; #1;
        chk("R2", "all requests", 32'(stall_cause), 5);
        next_slot(); idle_inputs(); imiss_req = 1; dmiss_req = 1; alu_busy_req = 1; #1;
        chk("R2", "imiss over dmiss", 32'(stall_cause), 1);
        next_slot(); idle_inputs(); dmiss_req = 1; lduse_ext_req = 1; #1;
        chk("R2", "dmiss over lduse", 32'(stall_cause), 2);
        next_slot(); idle_inputs(); lduse_ext_req = 1; alu_busy_req = 1; #1;
        chk("R2", "lduse over alu", 32'(stall_cause), 3);
        next_slot(); idle_inputs(); #1;
    endtask

    task automatic test_freeze();
        next_slot(); idle_inputs(); resync_wb_req = 1; #1;
        chk("R3", "resync freezes all", 32'(ens()), 0);
        next_slot(); idle_inputs(); dmiss_req = 1; #1;
        chk("R3", "dmiss freezes all", 32'(ens()), 0);
        chk("R4", "no bubble on dmiss", 32'(exe_bubble), 0);
        next_slot(); idle_inputs(); alu_busy_req = 1; #1;
        chk("R3", "alu freezes all", 32'(ens()), 0);
        next_slot(); idle_inputs(); imiss_req = 1; #1;
        chk("R4", "imiss front freeze", 32'(ens()), 5'b00111);
        chk("R4", "imiss bubble", 32'(exe_bubble), 1);
        next_slot(); idle_inputs(); lduse_ext_req = 1; #1;
        chk("R4", "lduse front freeze", 32'(ens()), 5'b00111);
        chk("R4", "lduse bubble", 32'(exe_bubble), 1);
        next_slot(); idle_inputs(); #1;
        chk("R11", "enables after stall", 32'(ens()), 5'b11111);
    endtask

    task automatic test_load_use();
        next_slot(); idle_inputs(); exe_is_load = 1; exe_rd = 5'd7; dec_rs1 = 5'd7; dec_rs2 = 5'd2; #1;
        chk("R5", "rs1 match cause", 32'(stall_cause), 3);
        chk("R5", "rs1 match bubble", 32'(exe_bubble), 1);
        // load has advanced: dependent instruction now in execute
        next_slot(); exe_is_load = 0; exe_rd = 5'd9; #1;
        chk("R5", "single bubble", 32'(exe_bubble), 0);
        chk("R5", "hazard gone", 32'(stall_cause), 0);
        next_slot(); idle_inputs(); exe_is_load = 1; exe_rd = 5'd12; dec_rs1 = 5'd1; dec_rs2 = 5'd12; #1;
        chk("R5", "rs2 match cause", 32'(stall_cause), 3);
        next_slot(); idle_inputs(); exe_is_load = 1; exe_rd = 5'd0; dec_rs1 = 5'd0; #1;
        chk("R5", "x0 destination ignored", 32'(stall_cause), 0);
        next_slot(); idle_inputs(); exe_is_load = 0; exe_rd = 5'd4; dec_rs1 = 5'd4; #1;
        chk("R5", "non-load ignored", 32'(stall_cause), 0);
        next_slot(); idle_inputs(); exe_is_load = 1; exe_rd = 5'd4; dec_rs1 = 5'd4; dmiss_req = 1; #1;
        chk("R5", "dmiss outranks hazard", 32'(stall_cause), 2);
        next_slot(); idle_inputs(); #1;
    endtask

    task automatic test_flush_gate();
        next_slot(); idle_inputs(); dec_flush_req = 1; #1;
        chk("R7", "decode flush passes", 32'(dec_flush), 1);
        chk("R7", "execute flush quiet", 32'(exe_flush), 0);
        next_slot(); idle_inputs(); #1;
        chk("R7", "no leftover flush", 32'(dec_flush), 0);
        // request under a data miss
        next_slot(); idle_inputs(); dmiss_req = 1; dec_flush_req = 1; exe_flush_req = 1; #1;
        chk("R6", "decode flush held", 32'(dec_flush), 0);
        chk("R6", "execute flush held", 32'(exe_flush), 0);
        next_slot(); dec_flush_req = 0; exe_flush_req = 0; dmiss_req = 0; alu_busy_req = 1; #1;
        chk("R6", "still held under alu", {30'd0, exe_flush, dec_flush}, 0);
        next_slot(); alu_busy_req = 0; #1;
        chk("R7", "deferred decode flush", 32'(dec_flush), 1);
        chk("R7", "deferred execute flush", 32'(exe_flush), 1);
        next_slot(); #1;
        chk("R7", "deferred flush one cycle", {30'd0, exe_flush, dec_flush}, 0);
        // imiss and resync stalls also hold
        next_slot(); idle_inputs(); imiss_req = 1; exe_flush_req = 1; #1;
        chk("R6", "imiss holds flush", 32'(exe_flush), 0);
        next_slot(); imiss_req = 0; exe_flush_req = 0; resync_wb_req = 1; #1;
        chk("R6", "resync wb holds flush", 32'(exe_flush), 0);
        next_slot(); resync_wb_req = 0; lduse_ext_req = 1; #1;
        chk("R7", "released under lduse", 32'(exe_flush), 1);
        chk("R7", "decode not flushed", 32'(dec_flush), 0);
        next_slot(); idle_inputs(); lduse_ext_req = 1; dec_flush_req = 1; #1;
        chk("R7", "lduse does not hold", 32'(dec_flush), 1);
        next_slot(); idle_inputs(); #1;
    endtask

    task automatic test_reset_pending();
        next_slot(); idle_inputs(); dmiss_req = 1; dec_flush_req = 1; #1;
        chk("R6", "held before reset", 32'(dec_flush), 0);
        next_slot(); rst_n = 0; idle_inputs(); #1;
        next_slot(); rst_n = 1; #1;
        chk("R12", "pending cleared by reset", {30'd0, exe_flush, dec_flush}, 0);
        next_slot(); #1;
        chk("R12", "still clear", {30'd0, exe_flush, dec_flush}, 0);
    endtask

    task automatic test_resync();
        next_slot(); idle_inputs(); exe_is_fencei = 1; exe_pc_next = 32'h0000_1a04; #1;
        chk("R8", "resync instruction", 32'(resync), 1);
        chk("R8", "resync pc", resync_pc, 32'h0000_1a04);
        next_slot(); idle_inputs(); exe_csr_we = 1; exe_csr_addr = 12'h301; exe_pc_next = 32'h0000_2002; #1;
        chk("R8", "isa csr write", 32'(resync), 1);
        chk("R8", "isa csr pc", resync_pc, 32'h0000_2002);
        next_slot(); idle_inputs(); exe_csr_we = 1; exe_csr_addr = 12'h300; #1;
        chk("R8", "other csr ignored", 32'(resync), 0);
        next_slot(); idle_inputs(); exe_csr_we = 0; exe_csr_addr = 12'h301; #1;
        chk("R8", "csr read ignored", 32'(resync), 0);
        next_slot(); idle_inputs(); exe_is_fencei = 1; dmiss_req = 1; #1;
        chk("R8", "resync under stall", 32'(resync), 1);
        next_slot(); idle_inputs(); #1;
    endtask

    task automatic test_forwarding();
        next_slot(); idle_inputs(); exe_rs1 = 5'd3; mem_rd = 5'd3; mem_rf_we = 1; #1;
        chk("R9", "mem forward a", 32'(fwd_a), 1);
        chk("R9", "b from regfile", 32'(fwd_b), 0);
        wb_rd = 5'd3; wb_rf_we = 1; #1;
        chk("R9", "mem over wb", 32'(fwd_a), 1);
        mem_rf_we = 0; #1;
        chk("R9", "wb forward a", 32'(fwd_a), 2);
        next_slot(); idle_inputs(); exe_rs2 = 5'd17; wb_rd = 5'd17; wb_rf_we = 1; #1;
        chk("R9", "wb forward b", 32'(fwd_b), 2);
        next_slot(); idle_inputs(); exe_rs1 = 0; exe_rs2 = 0; mem_rd = 0; mem_rf_we = 1; wb_rd = 0; wb_rf_we = 1; #1;
        chk("R9", "x0 never forwarded", {28'd0, fwd_b, fwd_a}, 0);
        chk("R10", "x0 never bypassed", {30'd0, byp_b, byp_a}, 0);
        next_slot(); idle_inputs(); dec_rs1 = 5'd8; dec_rs2 = 5'd9; wb_rd = 5'd9; wb_rf_we = 1; #1;
        chk("R10", "bypass b", {30'd0, byp_b, byp_a}, 2'b10);
        wb_rf_we = 0; #1;
        chk("R10", "no bypass without write", {30'd0, byp_b, byp_a}, 0);
        next_slot(); idle_inputs(); #1;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        test_reset();
        test_encoding();
        test_priority();
        test_freeze();
        test_load_use();
        test_flush_gate();
        test_reset_pending();
        test_resync();
        test_forwarding();
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

endmodule